// File: doc/BRIEF.md
# Fibonacci Universal Code Encoder

This block turns a symbol rank into a self-delimiting Fibonacci codeword. The rank is 1 for the most frequent symbol, 2 for the next, and so on. A rank is a positive integer that arrives on a valid/ready input. The block finds the rank's Zeckendorf sum, which is a sum of Fibonacci numbers with no two neighbours. It builds that sum by greedy subtraction from a table of constants computed at elaboration. It then streams the codeword one bit per cycle. For each term, smallest first, the stream carries a 1 if the term is in the sum and a 0 if not. A closing 1 bit follows, so every codeword ends in the pair "11".

While the bits stream out, the whole codeword is also held on a parallel bus. The codeword is left-aligned and comes with its length in bits. Frequency counting, rank assignment and decoding belong to other blocks. With the default 32-bit rank, the longest codeword is 47 bits. The parallel bus is 48 bits wide.

Top module: `fibenc_top`

## Requirements
- R1: For ranks 1, 2, 3 and 4, the serial bit sequences are 1,1 then 0,1,1 then 0,0,1,1 then 1,0,1,1. In general, emitted bit number k (k = 0 first) is 1 exactly when the Fibonacci number F(k+2) is in the rank's greedy Zeckendorf sum, where F(2)=1 and F(3)=2. The bit after the largest selected term is a closing 1.
- R2: Every codeword ends with two consecutive 1 bits, and no earlier pair of adjacent bits in that codeword is 1,1.
- R3: The codeword length equals the index k of the largest selected term plus 2. Rank 3,524,577 yields 32 bits. Rank 3,524,578 yields 31 zeros followed by 1,1 (33 bits).
- R4: Rank 4,294,967,295 (the largest 32-bit rank) yields a 47-bit codeword, and no codeword exceeds 47 bits.
- R5: While a codeword streams, par_valid is high and par_code holds the codeword unchanged. Emitted bit 0 sits at par_code[47], later bits sit at descending positions, and every bit below the codeword is 0. par_len gives the length.
- R6: A rank of 0 accepted on the input raises err_rank0 for exactly one cycle, starting the cycle after acceptance. No bit is emitted for it, and in_ready stays high.
- R7: After a nonzero rank is accepted, in_ready is low until the cycle after out_last. Any in_valid during that time is ignored and produces no later codeword.
- R8: out_valid is high for exactly the codeword length, in consecutive cycles. out_last is high only on the final bit.
- R9: After reset, in_ready is 1 and out_valid, out_last, err_rank0 and par_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rank present |
| in_ready | output | 1 | Block can accept a rank |
| in_rank | input | 32 | Symbol rank, 1 = most frequent |
| err_rank0 | output | 1 | One-cycle pulse: a rank of 0 was accepted |
| out_valid | output | 1 | Serial bit present |
| out_bit | output | 1 | Serial codeword bit, smallest term first |
| out_last | output | 1 | Closing bit of the codeword |
| par_valid | output | 1 | Parallel codeword valid |
| par_code | output | 48 | Left-aligned codeword |
| par_len | output | 6 | Codeword length in bits |

## Verification
The bench targets the following boundaries:

- **Boundary ranks 3,524,577 and 3,524,578.** A table or comparator that is off by one index would move the length across the 32/33-bit boundary.
- **Largest 32-bit rank.** A truncated table or a narrow length field would shorten or wrap this 47-bit codeword.
- **Pairs of adjacent terms.** Ranks whose sums contain such pairs test whether a design keeps an inner "11" or drops the closing 1.
- **Rank 0.** This checks that a design neither emits a spurious codeword nor stalls the input.
- **Input during a busy interval.** A rank offered while the block is busy checks that a leaky handshake does not start a second codeword.

// File: rtl/fibenc_pkg.sv
package fibenc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_SEND = 2'd2
   } enc_state_e;

   // Fibonacci number F(k) with F(0)=0, F(1)=1; valid for k <= 93.
   function automatic longint unsigned fib_num(input int k);
      longint unsigned a;
      longint unsigned b;
      longint unsigned t;
      a = 64'd0;
      b = 64'd1;
      for (int i = 0; i < k; i++) begin
         t = a + b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   // Number of terms F(2), F(3), ... that do not exceed 2^w - 1.
   function automatic int fib_terms(input int w);
      longint unsigned lim;
      int n;
      lim = (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      n = 0;
      for (int k = 2; k < 93; k++) begin
         if (fib_num(k) <= lim) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/fibenc_table.sv
module fibenc_table
   import fibenc_pkg::*;
#(
   parameter int RANK_W = 32,
   parameter int NT     = 46
) (
   output logic [NT-1:0][RANK_W-1:0] fib_o
);

   // Entry j holds F(j+2); computed at elaboration, no stored list.
   for (genvar j = 0; j < NT; j++) begin : g_term
      localparam longint unsigned VAL = fib_num(j + 2);
      assign fib_o[j] = RANK_W'(VAL);
   end

endmodule

// File: rtl/fibenc_zeck.sv
module fibenc_zeck #(
   parameter int RANK_W   = 32,
   parameter int NT       = 46,
   parameter int IDX_W    = 6,
   parameter bit SKIP_ADJ = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [RANK_W-1:0]         rank_i,
   input  logic [NT-1:0][RANK_W-1:0] fib_i,
   output logic                      done_o,
   output logic [NT-1:0]             terms_o,
   output logic [IDX_W-1:0]          top_o
);

   localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(NT - 1);

   logic [RANK_W-1:0] residue;
   logic [IDX_W-1:0]  idx;
   logic              busy;
   logic              found;
   logic [RANK_W-1:0] cur_fib;
   logic              take;
   logic [IDX_W-1:0]  step;

   assign cur_fib = fib_i[idx];
   assign take    = busy && (residue >= cur_fib);

   // Variant: after a term is taken its lower neighbour can never be taken,
   // so the scan may jump over it.
   if (SKIP_ADJ) begin : g_skip
      assign step = take ? IDX_W'(2) : IDX_W'(1);
   end else begin : g_plain
      assign step = IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         residue <= '0;
         idx     <= '0;
         busy    <= 1'b0;
         found   <= 1'b0;
         done_o  <= 1'b0;
         terms_o <= '0;
         top_o   <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy) begin
            residue <= rank_i;
            idx     <= IDX_HI;
            busy    <= 1'b1;
            found   <= 1'b0;
            terms_o <= '0;
         end else if (busy) begin
            if (take) begin
               residue      <= residue - cur_fib;
               terms_o[idx] <= 1'b1;
               if (!found) begin
                  top_o <= idx;
                  found <= 1'b1;
               end
            end
            if (idx < step) begin
               busy   <= 1'b0;
               done_o <= 1'b1;
            end else begin
               idx <= idx - step;
            end
         end
      end
   end

   AST_RESIDUE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (residue == '0));                                        // R1
   AST_NO_ADJ_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((terms_o & (terms_o >> 1)) == '0));                     // R2

endmodule

// File: rtl/fibenc_serial.sv
module fibenc_serial #(
   parameter int CODE_W = 48,
   parameter int LEN_W  = 6,
   parameter int NT     = 46,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [NT-1:0]     terms_i,
   input  logic [IDX_W-1:0]  top_i,
   output logic              out_valid,
   output logic              out_bit,
   output logic              out_last,
   output logic              par_valid,
   output logic [CODE_W-1:0] par_code,
   output logic [LEN_W-1:0]  par_len
);

   logic [CODE_W-1:0] code_nx;
   logic [LEN_W-1:0]  len_nx;
   logic [CODE_W-1:0] shreg;
   logic [LEN_W-1:0]  cnt;

   always_comb begin
      code_nx = '0;
      for (int j = 0; j < NT; j++) begin
         code_nx[CODE_W-1-j] = terms_i[j];
      end
      code_nx[CODE_W-2-int'(top_i)] = 1'b1;
   end
   assign len_nx = LEN_W'(top_i) + LEN_W'(2);

   assign out_bit  = shreg[CODE_W-1];
   assign out_last = out_valid && (cnt == par_len - LEN_W'(1));
   assign par_valid = out_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         shreg     <= '0;
         cnt       <= '0;
         par_code  <= '0;
         par_len   <= '0;
      end else if (load_i) begin
         out_valid <= 1'b1;
         shreg     <= code_nx;
         cnt       <= '0;
         par_code  <= code_nx;
         par_len   <= len_nx;
      end else if (out_valid) begin
         shreg <= shreg << 1;
         cnt   <= cnt + LEN_W'(1);
         if (out_last) out_valid <= 1'b0;
      end
   end

   AST_TAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_bit && $past(out_bit) && $past(out_valid)));      // R2
   AST_NO_INNER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && $past(out_bit) && out_bit)
         |-> out_last);                                                   // R2
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (par_len >= LEN_W'(2) && par_len <= LEN_W'(NT + 1))); // R4
   AST_PAR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (par_valid && $past(par_valid)) |-> $stable(par_code));             // R5

endmodule

// File: rtl/fibenc_top.sv
module fibenc_top
   import fibenc_pkg::*;
#(
   parameter int RANK_W   = 32,
   parameter int CODE_W   = 48,
   parameter int LEN_W    = 6,
   parameter bit SKIP_ADJ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [RANK_W-1:0] in_rank,
   output logic              err_rank0,
   output logic              out_valid,
   output logic              out_bit,
   output logic              out_last,
   output logic              par_valid,
   output logic [CODE_W-1:0] par_code,
   output logic [LEN_W-1:0]  par_len
);

   localparam int NT    = fib_terms(RANK_W);
   localparam int IDX_W = (NT > 1) ? $clog2(NT) : 1;

   if (RANK_W < 2 || RANK_W > 63) begin : g_bad_rank_w
      $error("fibenc_top: RANK_W must lie in 2..63");
   end
   if (CODE_W < NT + 1) begin : g_bad_code_w
      $error("fibenc_top: CODE_W too small for the longest codeword");
   end
   if ((1 << LEN_W) <= CODE_W) begin : g_bad_len_w
      $error("fibenc_top: LEN_W cannot hold the codeword length");
   end

   enc_state_e state;
   logic       accept;
   logic       start;
   logic       done;
   logic [NT-1:0][RANK_W-1:0] fib_tab;
   logic [NT-1:0]             terms;
   logic [IDX_W-1:0]          top;

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign start    = accept && (in_rank != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         err_rank0 <= 1'b0;
      end else begin
         err_rank0 <= accept && (in_rank == '0);
         unique case (state)
            ST_IDLE: if (start)    state <= ST_SCAN;
            ST_SCAN: if (done)     state <= ST_SEND;
            ST_SEND: if (out_last) state <= ST_IDLE;
            default:               state <= ST_IDLE;
         endcase
      end
   end

   fibenc_table #(.RANK_W(RANK_W), .NT(NT)) i_table (
      .fib_o (fib_tab)
   );

   fibenc_zeck #(.RANK_W(RANK_W), .NT(NT), .IDX_W(IDX_W), .SKIP_ADJ(SKIP_ADJ)) i_zeck (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .rank_i  (in_rank),
      .fib_i   (fib_tab),
      .done_o  (done),
      .terms_o (terms),
      .top_o   (top)
   );

   fibenc_serial #(.CODE_W(CODE_W), .LEN_W(LEN_W), .NT(NT), .IDX_W(IDX_W)) i_serial (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (done),
      .terms_i   (terms),
      .top_i     (top),
      .out_valid (out_valid),
      .out_bit   (out_bit),
      .out_last  (out_last),
      .par_valid (par_valid),
      .par_code  (par_code),
      .par_len   (par_len)
   );

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid);                                           // R7
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_rank0 |-> (!out_valid && in_ready));                            // R6
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_rank0 |-> $past(in_valid && in_ready && in_rank == '0));        // R6

endmodule

// File: tb/test_fibenc_top.sv
`timescale 1ns/1ps
module test_fibenc_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_rank = '0;
   logic        err_rank0;
   logic        out_valid, out_bit, out_last, par_valid;
   logic [47:0] par_code;
   logic [5:0]  par_len;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   longint unsigned fibs [0:60];

   always #2 clk = ~clk;

   fibenc_top i_fibenc_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rank(in_rank), .err_rank0(err_rank0), .out_valid(out_valid),
      .out_bit(out_bit), .out_last(out_last), .par_valid(par_valid),
      .par_code(par_code), .par_len(par_len)
   );

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Expected codeword from the requirement: greedy terms F(k+2), closing 1.
   task automatic model(input longint unsigned rank, output logic [47:0] code,
                        output int len);
      longint unsigned r = rank;
      int top = -1;
      code = '0;
      for (int k = 46; k >= 0; k--) begin
         if (fibs[k+2] <= r) begin
            r -= fibs[k+2];
            code[47-k] = 1'b1;
            if (top < 0) top = k;
         end
      end
      code[47-(top+1)] = 1'b1;
      len = top + 2;
   endtask

   task automatic send_rank(input logic [31:0] rank);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_rank  = rank;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic collect(output logic [47:0] ser, output int nbits,
                          output logic [47:0] pc, output int pl, output bit bad);
      int guard = 0;
      ser = '0; nbits = 0; pc = '0; pl = 0; bad = 1'b0;
      while (!out_valid && guard < 300) begin
         @(negedge clk);
         guard++;
      end
      pc = par_code;
      pl = int'(par_len);
      while (1) begin
         if (!out_valid || !par_valid || nbits >= 48 || par_code != pc) begin
            bad = 1'b1;
            break;
         end
         ser[47-nbits] = out_bit;
         nbits++;
         if (out_last) break;
         @(negedge clk);
      end
   endtask

   task automatic encode_check(input logic [31:0] rank, input string req);
      logic [47:0] ser, pc, exp_code;
      int nb, pl, exp_len;
      bit bad;
      model(rank, exp_code, exp_len);
      send_rank(rank);
      collect(ser, nb, pc, pl, bad);
      chk(!bad, {req, " R8 contiguous stream"}, nb, exp_len);
      chk(nb == exp_len, {req, " R8 bit count"}, nb, exp_len);
      chk(ser == exp_code, {req, " R1 serial code"}, ser, exp_code);
      chk(pc == exp_code && pl == exp_len, {req, " R5 parallel code"}, pc, exp_code);
      chk(ser[47-(nb-1)] && ser[47-(nb-2)], {req, " R2 tail 11"}, ser, exp_code);
      begin
         bit inner = 1'b0;
         for (int j = 0; j + 2 < nb; j++)
            if (ser[47-j] && ser[46-j]) inner = 1'b1;
         chk(!inner, {req, " R2 no inner 11"}, ser, exp_code);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
      chk(!out_valid && !out_last && !err_rank0 && !par_valid, "R9 outputs idle",
          {out_valid, out_last, err_rank0, par_valid}, 0);
   endtask

   task automatic t_small_ranks();
      logic [47:0] ser, pc;
      int nb, pl;
      bit bad;
      logic [47:0] lit [1:4];
      int litn [1:4];
      lit[1] = 48'b11 << 46;   litn[1] = 2;
      lit[2] = 48'b011 << 45;  litn[2] = 3;
      lit[3] = 48'b0011 << 44; litn[3] = 4;
      lit[4] = 48'b1011 << 44; litn[4] = 4;
      for (int r = 1; r <= 4; r++) begin
         send_rank(32'(r));
         collect(ser, nb, pc, pl, bad);
         chk(!bad && ser == lit[r] && nb == litn[r], "R1 literal codeword", ser, lit[r]);
      end
   endtask

   task automatic t_patterns();
      logic [31:0] ranks [0:9];
      ranks[0] = 5;   ranks[1] = 7;   ranks[2] = 12;   ranks[3] = 33;
      ranks[4] = 100; ranks[5] = 143; ranks[6] = 1000; ranks[7] = 32'hAAAA_5555;
      ranks[8] = 32'h8000_0000; ranks[9] = 54;
      for (int i = 0; i < 10; i++) encode_check(ranks[i], "R1 pattern");
   endtask

   task automatic t_boundary();
      logic [47:0] ser, pc;
      int nb, pl;
      bit bad;
      send_rank(32'd3524577);
      collect(ser, nb, pc, pl, bad);
      chk(!bad && nb == 32 && pl == 32, "R3 rank 3524577 length", nb, 32);
      send_rank(32'd3524578);
      collect(ser, nb, pc, pl, bad);
      chk(!bad && nb == 33, "R3 rank 3524578 length", nb, 33);
      chk(ser == (48'b11 << 15), "R3 rank 3524578 pattern", ser, 48'b11 << 15);
      send_rank(32'hFFFF_FFFF);
      collect(ser, nb, pc, pl, bad);
      chk(!bad && nb == 47 && pl == 47, "R4 max rank length", nb, 47);
      encode_check(32'hFFFF_FFFF, "R4 max rank");
   endtask

   task automatic t_zero();
      int seen = 0;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_rank  = 32'd0;
      @(negedge clk);
      in_valid = 1'b0;
      chk(err_rank0 == 1'b1, "R6 err pulse", err_rank0, 1);
      chk(in_ready == 1'b1, "R6 ready kept", in_ready, 1);
      @(negedge clk);
      chk(err_rank0 == 1'b0, "R6 err one cycle", err_rank0, 0);
      for (int i = 0; i < 80; i++) begin
         if (out_valid) seen++;
         @(negedge clk);
      end
      chk(seen == 0, "R6 nothing emitted", seen, 0);
   endtask

   task automatic t_busy_ignore();
      logic [47:0] ser, pc, exp_code;
      int nb, pl, exp_len, seen, rdy;
      bit bad;
      model(64'd100, exp_code, exp_len);
      send_rank(32'd100);
      rdy = 0;
      in_valid = 1'b1;
      in_rank  = 32'd9;
      for (int i = 0; i < 3; i++) begin
         if (in_ready) rdy++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk(rdy == 0, "R7 ready low while busy", rdy, 0);
      collect(ser, nb, pc, pl, bad);
      chk(!bad && ser == exp_code, "R7 first codeword intact", ser, exp_code);
      @(negedge clk);
      chk(in_ready == 1'b1, "R7 ready after last", in_ready, 1);
      seen = 0;
      for (int i = 0; i < 80; i++) begin
         if (out_valid) seen++;
         @(negedge clk);
      end
      chk(seen == 0, "R7 busy input ignored", seen, 0);
   endtask

   initial begin
      fibs[0] = 0;
      fibs[1] = 1;
      for (int k = 2; k <= 60; k++) fibs[k] = fibs[k-1] + fibs[k-2];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_small_ranks();
      t_patterns();
      t_boundary();
      t_zero();
      t_busy_ignore();
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule